// File: doc/BRIEF.md
# Windowed Peripheral Register Decoder

This block sits behind a 128 KiB memory-mapped window and turns each host access into a strobe for exactly one register target: a peripheral register port, a DMA channel register bank, or the local interrupt register group. The decode is hierarchical. Offset bit 16 picks device space, bit 15 picks DMA space, and an access with neither bit set reaches the interrupt group. Inside device space, every device derives its register index from its own slice of the offset.

Two targets live inside the decoder. The first is a board status word that carries an active-low strap pin. The second is a paged indirect byte window into NVRAM: a high-address register, written through its own device slot, supplies the page, and the data slot adds an in-page offset to it. The host bus is little-endian and the internal registers are big-endian, so write data and read data pass through a size-dependent byte swap. Read data comes from a register and is valid one clock after the read strobe.

The peripherals and the DMA engines are outside this block. Each target returns its read data combinationally on a shared flat input bus while its select is high.

Top module: `mmio_window_decoder`

## Requirements
- R1: With `acc_off[16]`=1 the access goes to device space, device number `acc_off[15:12]`. With bit 16 clear and bit 15 set it goes to DMA space. With both clear it selects the interrupt group (`tgt_sel` bit 12) with `tgt_idx` = `acc_off[7:0]`.
- R2: Devices 0 (storage, sel bit 0), 3 (serial, sel bit 2) and 5 (floppy, sel bit 4) use `tgt_idx` = `acc_off[7:4]`. Device 1 (network, sel bit 1) uses `tgt_idx` = `acc_off[8:4]`.
- R3: Device 2 aliases the serial port (sel bit 2). If `acc_off[7:0]` < 16, `tgt_idx` = {k[0], k[3:1]} with k = `acc_off[4:1]`. Otherwise `tgt_idx` = `acc_off[7:4]`.
- R4: Devices 6 and 7 both select the timer/keyboard port (sel bit 5) with `tgt_idx` = `acc_off[12:9]`. Device 4 (audio, sel bit 3) uses `tgt_idx` = `acc_off[7:0]`.
- R5: In DMA space the channel is `acc_off[11:8]`. Channel 1 (sel bit 9) and channel 8 (sel bit 10) get `tgt_idx` = `acc_off[7:0]`. Every other channel selects nothing.
- R6: A write to device 0xD loads the size-swapped write data, truncated to NV_HI_W bits, into the NVRAM page register. Device 0xF selects NVRAM (sel bit 11) with `tgt_idx` = `acc_off[8:4]` and `nv_addr` = page*32 + `acc_off[8:4]`.
- R7: A read of device 0xA returns the word {23'b0, `strap_n`, 8'b0}, size-swapped. For a word read this puts `strap_n` at bit 16.
- R8: Devices 0xB, 0xC and 0xE (sel bits 6, 7, 8) are selected only when `aux_present` bit 0, 1 or 2 respectively is set. Otherwise they select nothing and read 0.
- R9: Unmapped locations select nothing and read 0. These are device 8, device 9, reads of device 0xD, writes of device 0xA, and absent auxiliary ports.
- R10: Size 2 (word) reverses all four bytes. Size 1 (half) returns {16'h0, d[7:0], d[15:8]}. Size 0 (byte) passes data unchanged. The swap applies to both `tgt_wdata` and `acc_rdata`.
- R11: `acc_rdata` is 0 after reset. It loads the swapped read value at the clock edge that ends a read strobe and holds in every other cycle.
- R12: `tgt_sel` is zero whenever `acc_en` is low, and at most one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 half, 2 word |
| acc_off | input | 17 | Offset inside the window |
| acc_wdata | input | 32 | Host write data (little-endian) |
| acc_rdata | output | 32 | Registered host read data |
| strap_n | input | 1 | Active-low board strap pin |
| aux_present | input | 3 | Presence of auxiliary ports 0xB, 0xC, 0xE |
| tgt_rdata_flat | input | 416 | Target read data, 32 bits per target, indexed by sel bit |
| tgt_sel | output | 13 | One-hot target select |
| tgt_wr | output | 1 | Write qualifier for the selected target |
| tgt_idx | output | 8 | Register index for the selected target |
| tgt_wdata | output | 32 | Swapped write data |
| nv_addr | output | 13 | NVRAM byte address |

## Verification
The bench goes after the serial alias boundary at low byte 15 versus 16. A decoder that compares the wrong bits would send offset 0x2010 through the lookup and return a scrambled index. It walks DMA channels next to the two live ones; a partial channel compare would light a select on channel 0 or 9. It writes the NVRAM page register at each access size, since a missing or misapplied swap yields a wrong page in `nv_addr`. It also reads unmapped slots right after a mapped read, which catches a read register that holds stale data instead of loading zero.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int NTGT     = 13;
  localparam int T_STOR   = 0;
  localparam int T_NET    = 1;
  localparam int T_SER    = 2;
  localparam int T_AUD    = 3;
  localparam int T_FLP    = 4;
  localparam int T_VIA    = 5;
  localparam int T_AUXB   = 6;
  localparam int T_AUXC   = 7;
  localparam int T_AUXE   = 8;
  localparam int T_DMA1   = 9;
  localparam int T_DMA8   = 10;
  localparam int T_NVRAM  = 11;
  localparam int T_IRQ    = 12;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  function automatic logic [31:0] host_swap(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    case (sz)
      SZ_WORD: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      SZ_HALF: r = {16'h0, d[7:0], d[15:8]};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] compat_map(input logic [3:0] k);
    return {k[0], k[3:1]};
  endfunction
endpackage

// File: rtl/mwd_space_decode.sv
module mwd_space_decode
  import mwd_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int AUX_N = 3
) (
  input  logic              en,
  input  logic              wr,
  input  logic [16:0]       off,
  input  logic [AUX_N-1:0]  aux_present,
  output logic [NTGT-1:0]   sel,
  output logic [IDX_W-1:0]  idx,
  output logic              page_wr,
  output logic              board_rd
);
  always_comb begin
    sel      = '0;
    idx      = '0;
    page_wr  = 1'b0;
    board_rd = 1'b0;
    if (en) begin
      if (off[16]) begin
        case (off[15:12])
          4'h0: begin sel[T_STOR] = 1'b1; idx = IDX_W'(off[7:4]); end
          4'h1: begin sel[T_NET]  = 1'b1; idx = IDX_W'(off[8:4]); end
          4'h2: begin
            sel[T_SER] = 1'b1;
            if (off[7:0] < 8'd16) idx = IDX_W'(compat_map(off[4:1]));
            else                  idx = IDX_W'(off[7:4]);
          end
          4'h3: begin sel[T_SER]  = 1'b1; idx = IDX_W'(off[7:4]); end
          4'h4: begin sel[T_AUD]  = 1'b1; idx = IDX_W'(off[7:0]); end
          4'h5: begin sel[T_FLP]  = 1'b1; idx = IDX_W'(off[7:4]); end
          4'h6, 4'h7: begin sel[T_VIA] = 1'b1; idx = IDX_W'(off[12:9]); end
          4'hA: board_rd = ~wr;
          4'hB: if (aux_present[0]) begin sel[T_AUXB] = 1'b1; idx = IDX_W'(off[8:4]); end
          4'hC: if (aux_present[1]) begin sel[T_AUXC] = 1'b1; idx = IDX_W'(off[8:4]); end
          4'hE: if (aux_present[2]) begin sel[T_AUXE] = 1'b1; idx = IDX_W'(off[8:4]); end
          4'hD: page_wr = wr;
          4'hF: begin sel[T_NVRAM] = 1'b1; idx = IDX_W'(off[8:4]); end
          default: ;
        endcase
      end else if (off[15]) begin
        case (off[11:8])
          4'h1: begin sel[T_DMA1] = 1'b1; idx = IDX_W'(off[7:0]); end
          4'h8: begin sel[T_DMA8] = 1'b1; idx = IDX_W'(off[7:0]); end
          default: ;
        endcase
      end else begin
        sel[T_IRQ] = 1'b1;
        idx        = IDX_W'(off[7:0]);
      end
    end
  end
endmodule

// File: rtl/mwd_nvram_page.sv
module mwd_nvram_page #(
  parameter int HI_W = 8,
  parameter int AW   = HI_W + 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page_wr,
  input  logic [31:0]   page_data,
  input  logic [4:0]    in_page,
  output logic [AW-1:0] nv_addr
);
  logic [HI_W-1:0] page_q, page_d;

  always_comb begin
    page_d = page_q;
    if (page_wr) page_d = page_data[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (page_wr) page_q <= page_d;
  end

  assign nv_addr = {page_q, 5'b0} + AW'(in_page);
endmodule

// File: rtl/mwd_rd_path.sv
module mwd_rd_path
  import mwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [1:0]           size,
  input  logic [NTGT-1:0]      sel,
  input  logic                 board_rd,
  input  logic                 strap_n,
  input  logic [NTGT*32-1:0]   rdata_flat,
  output logic [31:0]          rdata
);
  logic [31:0] tgt_rd [NTGT];
  logic [31:0] raw, rd_d, rd_q;

  genvar g;
  generate
    for (g = 0; g < NTGT; g++) begin : g_unpack
      assign tgt_rd[g] = rdata_flat[g*32 +: 32];
    end
  endgenerate

  always_comb begin
    raw = '0;
    for (int t = 0; t < NTGT; t++)
      if (sel[t]) raw = raw | tgt_rd[t];
    if (board_rd) raw = {23'b0, strap_n, 8'b0};
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = host_swap(raw, size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mwd_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int AUX_N   = 3,
  parameter int NV_HI_W = 8,
  localparam int NV_AW  = NV_HI_W + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [1:0]          acc_size,
  input  logic [16:0]         acc_off,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic                strap_n,
  input  logic [AUX_N-1:0]    aux_present,
  input  logic [NTGT*32-1:0]  tgt_rdata_flat,
  output logic [NTGT-1:0]     tgt_sel,
  output logic                tgt_wr,
  output logic [IDX_W-1:0]    tgt_idx,
  output logic [31:0]         tgt_wdata,
  output logic [NV_AW-1:0]    nv_addr
);
  logic page_wr, board_rd;

  assign tgt_wdata = host_swap(acc_wdata, acc_size);
  assign tgt_wr    = acc_en & acc_wr;

  mwd_space_decode #(.IDX_W(IDX_W), .AUX_N(AUX_N)) u_dec (
    .en(acc_en), .wr(acc_wr), .off(acc_off), .aux_present(aux_present),
    .sel(tgt_sel), .idx(tgt_idx), .page_wr(page_wr), .board_rd(board_rd)
  );

  mwd_nvram_page #(.HI_W(NV_HI_W), .AW(NV_AW)) u_page (
    .clk(clk), .rst_n(rst_n), .page_wr(page_wr), .page_data(tgt_wdata),
    .in_page(acc_off[8:4]), .nv_addr(nv_addr)
  );

  mwd_rd_path u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_en & ~acc_wr), .size(acc_size),
    .sel(tgt_sel), .board_rd(board_rd), .strap_n(strap_n),
    .rdata_flat(tgt_rdata_flat), .rdata(acc_rdata)
  );
endmodule

// File: rtl/mwd_chk.sv
module mwd_chk
  import mwd_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [16:0]       acc_off,
  input logic [NTGT-1:0]   tgt_sel,
  input logic [IDX_W-1:0]  tgt_idx,
  input logic [31:0]       acc_rdata
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R12
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_sel));

  // R12
  idle_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n) !acc_en |-> tgt_sel == '0);

  // R5
  dma_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_off[16:15] == 2'b01 && acc_off[11:8] != 4'h1 && acc_off[11:8] != 4'h8)
      |-> tgt_sel == '0);

  // R4
  via_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_off[16] && acc_off[15:13] == 3'b011)
      |-> (tgt_sel[T_VIA] && tgt_idx == IDX_W'(acc_off[12:9])));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(acc_en && !acc_wr)) |=> $stable(acc_rdata));
endmodule

bind mmio_window_decoder mwd_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_off(acc_off),
  .tgt_sel(tgt_sel), .tgt_idx(tgt_idx), .acc_rdata(acc_rdata)
);

// File: tb/sim_mmio_window_decoder.sv
module sim_mmio_window_decoder;
  import mwd_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_en, acc_wr, strap_n;
  logic [1:0] acc_size;
  logic [16:0] acc_off;
  logic [31:0] acc_wdata, acc_rdata, tgt_wdata;
  logic [2:0] aux_present;
  logic [NTGT*32-1:0] tgt_rdata_flat;
  logic [NTGT-1:0] tgt_sel;
  logic tgt_wr;
  logic [7:0] tgt_idx;
  logic [12:0] nv_addr;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mmio_window_decoder u0 (.*);

  for (genvar t = 0; t < NTGT; t++) begin : g_rd
    assign tgt_rdata_flat[t*32 +: 32] = 32'hA000_0000 | (t << 8) | t;
  end

  function automatic logic [31:0] swp(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd2) return {d[7:0], d[15:8], d[23:16], d[31:24]};
    if (s == 2'd1) return {16'h0, d[7:0], d[15:8]};
    return d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at negedge, comb outputs valid 2 ns later
  task automatic drive(input logic wr, input logic [16:0] off, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_off = off; acc_size = sz; acc_wdata = wd;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
    #2;
  endtask

  task automatic sel_chk(input string tag, input int t, input logic [7:0] idx);
    chk({tag, " sel"}, 32'(tgt_sel), (t < 0) ? 32'h0 : (32'h1 << t));
    if (t >= 0) chk({tag, " idx"}, 32'(tgt_idx), 32'(idx));
  endtask

  task automatic t_reset();
    chk("R11 reset rdata", acc_rdata, 32'h0);
    chk("R12 idle sel", 32'(tgt_sel), 32'h0);
  endtask

  task automatic t_spaces();
    drive(1'b0, 17'h0_0024, 2'd2, 0); sel_chk("R1 irq", T_IRQ, 8'h24);
    drive(1'b0, 17'h0_8134, 2'd2, 0); sel_chk("R5 dma1", T_DMA1, 8'h34);
    drive(1'b0, 17'h0_8808, 2'd2, 0); sel_chk("R5 dma8", T_DMA8, 8'h08);
    drive(1'b0, 17'h0_8000, 2'd2, 0); sel_chk("R5 dma0", -1, 0);
    drive(1'b0, 17'h0_8900, 2'd2, 0); sel_chk("R5 dma9", -1, 0);
    idle();
  endtask

  task automatic t_devices();
    drive(1'b0, 17'h1_01F0, 2'd0, 0); sel_chk("R2 stor", T_STOR, 8'h0F);
    drive(1'b0, 17'h1_11F0, 2'd0, 0); sel_chk("R2 net", T_NET, 8'h1F);
    drive(1'b0, 17'h1_3050, 2'd0, 0); sel_chk("R2 ser", T_SER, 8'h05);
    drive(1'b0, 17'h1_5070, 2'd0, 0); sel_chk("R2 flp", T_FLP, 8'h07);
    drive(1'b0, 17'h1_40AB, 2'd0, 0); sel_chk("R4 aud", T_AUD, 8'hAB);
    drive(1'b0, 17'h1_6A00, 2'd0, 0); sel_chk("R4 via6", T_VIA, 8'h05);
    drive(1'b0, 17'h1_7E00, 2'd0, 0); sel_chk("R4 via7", T_VIA, 8'h0F);
    idle();
  endtask

  task automatic t_compat();
    // k=off[4:1]=4'b0110 -> {0,011}=3
    drive(1'b0, 17'h1_200C, 2'd0, 0); sel_chk("R3 compat lo", T_SER, 8'h03);
    // k=4'b0111 (off 0x0E) -> {1,011}=0xB
    drive(1'b0, 17'h1_200E, 2'd0, 0); sel_chk("R3 compat 0E", T_SER, 8'h0B);
    drive(1'b0, 17'h1_2010, 2'd0, 0); sel_chk("R3 compat 16", T_SER, 8'h01);
    idle();
  endtask

  task automatic t_nvram();
    drive(1'b1, 17'h1_D000, 2'd2, 32'h0300_0000); chk("R6 pagewr nosel", 32'(tgt_sel), 0);
    drive(1'b0, 17'h1_F050, 2'd0, 0);
    sel_chk("R6 nv", T_NVRAM, 8'h05); chk("R6 addr word", 32'(nv_addr), 32'd101);
    drive(1'b1, 17'h1_D000, 2'd1, 32'h0000_0200);
    drive(1'b0, 17'h1_F010, 2'd0, 0); chk("R6 addr half", 32'(nv_addr), 32'd65);
    drive(1'b1, 17'h1_D000, 2'd0, 32'h0000_0007);
    drive(1'b0, 17'h1_F1F0, 2'd0, 0); chk("R6 addr byte", 32'(nv_addr), 32'd255);
    idle();
  endtask

  task automatic t_reads();
    drive(1'b0, 17'h1_0010, 2'd2, 0); idle();
    chk("R10 R11 word rd", acc_rdata, swp(32'hA000_0000, 2'd2));
    drive(1'b0, 17'h1_1010, 2'd1, 0); idle();
    chk("R10 half rd", acc_rdata, swp(32'hA000_0101, 2'd1));
    idle(); chk("R11 hold", acc_rdata, swp(32'hA000_0101, 2'd1));
    strap_n = 1'b1;
    drive(1'b0, 17'h1_A000, 2'd2, 0); chk("R9 board nosel", 32'(tgt_sel), 0); idle();
    chk("R7 board word", acc_rdata, 32'h0001_0000);
    strap_n = 1'b0;
    drive(1'b0, 17'h1_A000, 2'd2, 0); idle();
    chk("R7 board low", acc_rdata, 32'h0);
    drive(1'b0, 17'h0_8800, 2'd0, 0); idle();
    chk("R10 byte rd", acc_rdata, 32'hA000_0A0A);
    drive(1'b0, 17'h1_8000, 2'd2, 0); chk("R9 dev8 nosel", 32'(tgt_sel), 0); idle();
    chk("R9 dev8 rd", acc_rdata, 32'h0);
    drive(1'b0, 17'h0_0000, 2'd0, 0); idle();
    drive(1'b0, 17'h1_D000, 2'd2, 0); idle();
    chk("R9 devD rd", acc_rdata, 32'h0);
    drive(1'b1, 17'h1_A000, 2'd2, 32'h1234_5678); chk("R9 devA wr", 32'(tgt_sel), 0);
    chk("R10 wdata", tgt_wdata, 32'h7856_3412);
    chk("R12 wr qual", 32'(tgt_wr), 1);
    idle();
  endtask

  task automatic t_aux();
    aux_present = 3'b101;
    drive(1'b0, 17'h1_B030, 2'd2, 0); sel_chk("R8 auxB", T_AUXB, 8'h03);
    drive(1'b0, 17'h1_E030, 2'd2, 0); sel_chk("R8 auxE", T_AUXE, 8'h03);
    drive(1'b0, 17'h1_0000, 2'd0, 0); idle();
    drive(1'b0, 17'h1_C030, 2'd2, 0); sel_chk("R8 auxC absent", -1, 0); idle();
    chk("R8 absent rd", acc_rdata, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_size = 2'd0; acc_off = '0;
    acc_wdata = '0; strap_n = 1'b0; aux_present = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    t_reset();
    t_spaces();
    t_devices();
    t_compat();
    t_nvram();
    t_reads();
    t_aux();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule